// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative translation buffer whose contents are managed by software. Each slot holds one virtual tag that covers a pair of adjacent pages, an even page and an odd page, and each half of the pair points at its own physical frame. Every half has its own valid, dirty and cache-attribute bits. A per-slot page-size mask widens the pair from two 4 KiB pages up to larger sizes. The tag comparison then ignores the masked virtual-page bits, and the even/odd choice moves up to the bit just above the enlarged page offset.

Software drives the block through a set of register-style inputs: a tag word (virtual page and address-space identifier), two frame words (even and odd halves), a page-size mask word, an index word and a random slot number. It issues one of four commands: probe, indexed read, indexed write and random write. A command is accepted in any cycle where `cmd_valid` is high. Its results appear on the output registers one cycle later, with `done` high for that cycle. A separate combinational lookup port translates a virtual address under a given identifier and reports hit, valid, dirty, cache attribute and physical address.

The command sequencer is a two-state machine. `ST_IDLE` moves to `ST_RESP` when a command is accepted and otherwise stays put. `ST_RESP` stays in `ST_RESP` on a back-to-back command and returns to `ST_IDLE` otherwise. `done` is high exactly while the machine is in `ST_RESP`.

Top module: `ptlb_top`

## Requirements
- R1: After reset, `done`, `asid_flush` and all result outputs are zero, and every slot is cleared: tag 0, identifier 0, mask 0, global 0, and both halves invalid with frame 0.
- R2: An indexed write (`cmd_op`=2) stores into slot `idx_in` modulo the slot count. The fields are taken from the inputs as follows. The tag is `hi_in[31:13]` and the identifier is `hi_in[7:0]`. The mask is `mask_in[24:13]`. The global bit is `lo0_in[0]` AND `lo1_in[0]`. Each half takes valid from bit 1, dirty from bit 2, cache attribute from bits 5:3 and the 24-bit frame from bits 29:6 of its frame word (`lo0_in` is even, `lo1_in` is odd).
- R3: A random write (`cmd_op`=3) stores the same fields into slot `rand_in` instead of the indexed slot.
- R4: A probe (`cmd_op`=0) matches a slot when (its global bit is set OR its identifier equals `hi_in[7:0]`) AND its tag equals `hi_in[31:13]` on every bit not covered by the slot's mask. On a hit, `idx_out` becomes the slot number with all upper bits zero. When several slots match, the lowest-numbered one wins.
- R5: A probe that matches no slot sets `idx_out` to `idx_in` with bit 31 forced to 1.
- R6: An indexed read (`cmd_op`=1) of slot `idx_in` modulo the slot count returns three values. `hi_out` is {tag, 5'b0, identifier}. `mask_out` holds the stored mask in bits 24:13 and zero elsewhere. Each frame output is {2'b0, frame, attribute, dirty, valid, global}.
- R7: `asid_flush` is high together with `done` after an indexed read whose stored identifier differs from `hi_in[7:0]`, and is low in every other cycle.
- R8: `done` is high in exactly the cycle after each accepted command. A probe changes only `idx_out`, and writes change no result output.
- R9: The lookup port chooses the matching slot by the same rule as R4, using `lk_va[31:13]` and `lk_asid`. It selects the odd half when `lk_va` bit (12+k) is 1, where k is the count of low mask bits set. It reports that half's valid, dirty and attribute. `lk_pa` is the frame shifted left by 12, with its low 12+k bits replaced by those of `lk_va`.
- R10: Tag bits covered by a slot's mask play no part in probe or lookup matching.
- R11: A slot whose global bit is set matches any identifier, in both probe and lookup.
- R12: With no matching slot, `lk_hit`, `lk_valid`, `lk_dirty`, `lk_cattr` and `lk_pa` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command accepted this cycle |
| cmd_op | input | 2 | 0 probe, 1 indexed read, 2 indexed write, 3 random write |
| hi_in | input | 32 | Tag word: virtual page pair in 31:13, identifier in 7:0 |
| lo0_in | input | 32 | Even-half frame word |
| lo1_in | input | 32 | Odd-half frame word |
| mask_in | input | 32 | Page-size mask word, mask in 24:13 |
| idx_in | input | 32 | Index word |
| rand_in | input | IDX_W | Slot number for random writes |
| done | output | 1 | Command result valid |
| hi_out | output | 32 | Tag word returned by an indexed read |
| lo0_out | output | 32 | Even frame word returned by an indexed read |
| lo1_out | output | 32 | Odd frame word returned by an indexed read |
| mask_out | output | 32 | Mask word returned by an indexed read |
| idx_out | output | 32 | Probe result |
| asid_flush | output | 1 | Identifier changed by an indexed read |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup identifier |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_valid | output | 1 | Selected half valid |
| lk_dirty | output | 1 | Selected half dirty |
| lk_cattr | output | 3 | Selected half cache attribute |
| lk_pa | output | 36 | Physical address |

## Verification
The hardest case to reach from the ports is several slots matching one probe or lookup at the same time. Software is expected to avoid duplicates, and the reset contents make every empty slot look alike. The stimulus therefore writes the same tag and identifier into two slots, one through the random slot number and one at a higher index. It also writes enlarged-page slots whose tags differ from a probe only in masked bits. A long pseudo-random phase then draws tags from a four-entry pool and masks from three sizes, so that overlapping and global matches keep recurring while the behavioural model checks every cycle.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int REG_W      = 32;
    localparam int ASID_W     = 8;
    localparam int PMASK_W    = 12;
    localparam int PAGE_SHIFT = 12;
    localparam int VPN2_LSB   = PAGE_SHIFT + 1;
    localparam int VPN2_W     = REG_W - VPN2_LSB;
    localparam int PFN_LSB    = 6;
    localparam int PFN_W      = 24;
    localparam int CATTR_W    = 3;
    localparam int PA_W       = PFN_W + PAGE_SHIFT;
    localparam int SEL_W      = PMASK_W + 1;

    typedef enum logic [1:0] {
        OP_PROBE     = 2'd0,
        OP_READ      = 2'd1,
        OP_WRITE_IDX = 2'd2,
        OP_WRITE_RND = 2'd3
    } tlb_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctrl_state_e;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CATTR_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } tlb_half_t;

    typedef struct packed {
        logic [VPN2_W-1:0]  vpn2;
        logic [ASID_W-1:0]  asid;
        logic [PMASK_W-1:0] pmask;
        logic               glob;
        tlb_half_t          even;
        tlb_half_t          odd;
    } tlb_entry_t;

    function automatic tlb_half_t unpack_lo(input logic [REG_W-1:0] lo);
        tlb_half_t h;
        h.valid = lo[1];
        h.dirty = lo[2];
        h.cattr = lo[5:3];
        h.pfn   = lo[PFN_LSB +: PFN_W];
        return h;
    endfunction

    function automatic logic [REG_W-1:0] pack_lo(input tlb_half_t h, input logic g);
        logic [REG_W-1:0] r;
        r                     = '0;
        r[PFN_LSB +: PFN_W]   = h.pfn;
        r[5:3]                = h.cattr;
        r[2]                  = h.dirty;
        r[1]                  = h.valid;
        r[0]                  = g;
        return r;
    endfunction

    function automatic tlb_entry_t build_entry(
        input logic [REG_W-1:0] hi,
        input logic [REG_W-1:0] lo0,
        input logic [REG_W-1:0] lo1,
        input logic [REG_W-1:0] pmask_word
    );
        tlb_entry_t e;
        e.vpn2  = hi[REG_W-1:VPN2_LSB];
        e.asid  = hi[ASID_W-1:0];
        e.pmask = pmask_word[VPN2_LSB +: PMASK_W];
        e.glob  = lo0[0] & lo1[0];
        e.even  = unpack_lo(lo0);
        e.odd   = unpack_lo(lo1);
        return e;
    endfunction

    function automatic logic [VPN2_W-1:0] wide_mask(input logic [PMASK_W-1:0] m);
        return {{(VPN2_W-PMASK_W){1'b0}}, m};
    endfunction

endpackage

// File: rtl/ptlb_store.sv
module ptlb_store
    import ptlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_entry,
    output tlb_entry_t [NUM_ENTRIES-1:0] entries
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entries <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (wr_en && (wr_idx == IDX_W'(i))) begin
                    entries[i] <= wr_entry;
                end
            end
        end
    end

endmodule

// File: rtl/ptlb_cam.sv
module ptlb_cam
    import ptlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] entries,
    input  logic [VPN2_W-1:0]            vpn2,
    input  logic [ASID_W-1:0]            asid,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [NUM_ENTRIES-1:0] match;

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
            logic id_ok;
            logic tag_ok;
            assign id_ok  = entries[g].glob || (entries[g].asid == asid);
            assign tag_ok = ((entries[g].vpn2 ^ vpn2) & ~wide_mask(entries[g].pmask)) == '0;
            assign match[g] = id_ok && tag_ok;
        end
    endgenerate

    // lowest-numbered matching slot wins
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/ptlb_ctrl.sv
module ptlb_ctrl
    import ptlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  tlb_op_e           cmd_op,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [REG_W-1:0]  idx_in,
    input  logic [IDX_W-1:0]  rand_in,
    input  logic              probe_hit,
    input  logic [IDX_W-1:0]  probe_idx,
    input  tlb_entry_t        rd_entry,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              done,
    output logic [REG_W-1:0]  hi_out,
    output logic [REG_W-1:0]  lo0_out,
    output logic [REG_W-1:0]  lo1_out,
    output logic [REG_W-1:0]  mask_out,
    output logic [REG_W-1:0]  idx_out,
    output logic              asid_flush
);

    localparam int HI_GAP   = VPN2_LSB - ASID_W;
    localparam int MASK_TOP = REG_W - VPN2_LSB - PMASK_W;

    ctrl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = cmd_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = cmd_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state and command
    always_comb begin
        done   = (state_q == ST_RESP);
        rd_idx = idx_in[IDX_W-1:0];
        wr_en  = cmd_valid && ((cmd_op == OP_WRITE_IDX) || (cmd_op == OP_WRITE_RND));
        wr_idx = (cmd_op == OP_WRITE_RND) ? rand_in : idx_in[IDX_W-1:0];
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_out     <= '0;
            lo0_out    <= '0;
            lo1_out    <= '0;
            mask_out   <= '0;
            idx_out    <= '0;
            asid_flush <= 1'b0;
        end else begin
            asid_flush <= 1'b0;
            if (cmd_valid) begin
                unique case (cmd_op)
                    OP_PROBE: begin
                        if (probe_hit) begin
                            idx_out <= REG_W'(probe_idx);
                        end else begin
                            idx_out <= idx_in | {1'b1, {(REG_W-1){1'b0}}};
                        end
                    end
                    OP_READ: begin
                        hi_out     <= {rd_entry.vpn2, {HI_GAP{1'b0}}, rd_entry.asid};
                        mask_out   <= {{MASK_TOP{1'b0}}, rd_entry.pmask, {VPN2_LSB{1'b0}}};
                        lo0_out    <= pack_lo(rd_entry.even, rd_entry.glob);
                        lo1_out    <= pack_lo(rd_entry.odd, rd_entry.glob);
                        asid_flush <= (rd_entry.asid != cur_asid);
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
    import ptlb_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [REG_W-1:0]     hi_in,
    input  logic [REG_W-1:0]     lo0_in,
    input  logic [REG_W-1:0]     lo1_in,
    input  logic [REG_W-1:0]     mask_in,
    input  logic [REG_W-1:0]     idx_in,
    input  logic [IDX_W-1:0]     rand_in,
    output logic                 done,
    output logic [REG_W-1:0]     hi_out,
    output logic [REG_W-1:0]     lo0_out,
    output logic [REG_W-1:0]     lo1_out,
    output logic [REG_W-1:0]     mask_out,
    output logic [REG_W-1:0]     idx_out,
    output logic                 asid_flush,
    input  logic [REG_W-1:0]     lk_va,
    input  logic [ASID_W-1:0]    lk_asid,
    output logic                 lk_hit,
    output logic                 lk_valid,
    output logic                 lk_dirty,
    output logic [CATTR_W-1:0]   lk_cattr,
    output logic [PA_W-1:0]      lk_pa
);

    tlb_entry_t [NUM_ENTRIES-1:0] entries;
    tlb_entry_t                   wr_entry;
    tlb_entry_t                   rd_entry;
    tlb_entry_t                   lk_entry;
    logic                         wr_en;
    logic [IDX_W-1:0]             wr_idx;
    logic [IDX_W-1:0]             rd_idx;
    logic                         probe_hit;
    logic [IDX_W-1:0]             probe_idx;
    logic                         lk_match;
    logic [IDX_W-1:0]             lk_idx;
    tlb_op_e                      op;

    assign op       = tlb_op_e'(cmd_op);
    assign wr_entry = build_entry(hi_in, lo0_in, lo1_in, mask_in);
    assign rd_entry = entries[rd_idx];
    assign lk_entry = entries[lk_idx];

    ptlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .entries  (entries)
    );

    ptlb_cam #(.NUM_ENTRIES(NUM_ENTRIES)) u_probe_cam (
        .entries (entries),
        .vpn2    (hi_in[REG_W-1:VPN2_LSB]),
        .asid    (hi_in[ASID_W-1:0]),
        .hit     (probe_hit),
        .hit_idx (probe_idx)
    );

    ptlb_cam #(.NUM_ENTRIES(NUM_ENTRIES)) u_lookup_cam (
        .entries (entries),
        .vpn2    (lk_va[REG_W-1:VPN2_LSB]),
        .asid    (lk_asid),
        .hit     (lk_match),
        .hit_idx (lk_idx)
    );

    ptlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (op),
        .cur_asid   (hi_in[ASID_W-1:0]),
        .idx_in     (idx_in),
        .rand_in    (rand_in),
        .probe_hit  (probe_hit),
        .probe_idx  (probe_idx),
        .rd_entry   (rd_entry),
        .rd_idx     (rd_idx),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .done       (done),
        .hi_out     (hi_out),
        .lo0_out    (lo0_out),
        .lo1_out    (lo1_out),
        .mask_out   (mask_out),
        .idx_out    (idx_out),
        .asid_flush (asid_flush)
    );

    // half select and physical address formation for the lookup port
    logic [SEL_W-1:0] sel_bit;
    logic             odd_sel;
    tlb_half_t        half;
    logic [PA_W-1:0]  off_mask;
    logic [PA_W-1:0]  frame_base;

    always_comb begin
        sel_bit    = {1'b0, lk_entry.pmask} + SEL_W'(1);
        odd_sel    = |(lk_va[PAGE_SHIFT +: SEL_W] & sel_bit);
        half       = odd_sel ? lk_entry.odd : lk_entry.even;
        off_mask   = PA_W'({lk_entry.pmask, {PAGE_SHIFT{1'b1}}});
        frame_base = {half.pfn, {PAGE_SHIFT{1'b0}}};
        lk_hit     = lk_match;
        lk_valid   = lk_match & half.valid;
        lk_dirty   = lk_match & half.dirty;
        lk_cattr   = lk_match ? half.cattr : '0;
        lk_pa      = lk_match ? ((frame_base & ~off_mask) | (PA_W'(lk_va) & off_mask)) : '0;
    end

endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk
    import ptlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic               done,
    input logic [REG_W-1:0]   hi_out,
    input logic [REG_W-1:0]   lo0_out,
    input logic [REG_W-1:0]   lo1_out,
    input logic [REG_W-1:0]   mask_out,
    input logic [REG_W-1:0]   idx_out,
    input logic               asid_flush,
    input logic               lk_hit,
    input logic               lk_valid,
    input logic               lk_dirty,
    input logic [CATTR_W-1:0] lk_cattr,
    input logic [PA_W-1:0]    lk_pa
);

    a_r8_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> done);

    a_r8_no_done_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !done);

    a_r8_write_keeps_results: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[1]) |=> ($stable(hi_out) && $stable(lo0_out) && $stable(lo1_out)
                                      && $stable(mask_out) && $stable(idx_out)));

    a_r8_probe_keeps_read_results: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=> ($stable(hi_out) && $stable(lo0_out)
                                           && $stable(lo1_out) && $stable(mask_out)));

    a_r4_probe_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd0) |=> (idx_out[REG_W-1] || (idx_out < REG_W'(NUM_ENTRIES))));

    a_r7_flush_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        asid_flush |-> done);

    a_r7_flush_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 2'd1) |=> !asid_flush);

    a_r12_miss_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_valid && !lk_dirty && lk_cattr == '0 && lk_pa == '0));

endmodule

bind ptlb_top ptlb_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .done       (done),
    .hi_out     (hi_out),
    .lo0_out    (lo0_out),
    .lo1_out    (lo1_out),
    .mask_out   (mask_out),
    .idx_out    (idx_out),
    .asid_flush (asid_flush),
    .lk_hit     (lk_hit),
    .lk_valid   (lk_valid),
    .lk_dirty   (lk_dirty),
    .lk_cattr   (lk_cattr),
    .lk_pa      (lk_pa)
);

// File: tb/ptlb_top_tb.sv
module ptlb_top_tb;

    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid;
    logic [1:0]    cmd_op;
    logic [31:0]   hi_in, lo0_in, lo1_in, mask_in, idx_in;
    logic [IW-1:0] rand_in;
    logic          done;
    logic [31:0]   hi_out, lo0_out, lo1_out, mask_out, idx_out;
    logic          asid_flush;
    logic [31:0]   lk_va;
    logic [7:0]    lk_asid;
    logic          lk_hit, lk_valid, lk_dirty;
    logic [2:0]    lk_cattr;
    logic [35:0]   lk_pa;

    always #2 clk = ~clk;

    ptlb_top #(.NUM_ENTRIES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .hi_in(hi_in), .lo0_in(lo0_in), .lo1_in(lo1_in), .mask_in(mask_in),
        .idx_in(idx_in), .rand_in(rand_in), .done(done), .hi_out(hi_out),
        .lo0_out(lo0_out), .lo1_out(lo1_out), .mask_out(mask_out), .idx_out(idx_out),
        .asid_flush(asid_flush), .lk_va(lk_va), .lk_asid(lk_asid), .lk_hit(lk_hit),
        .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_cattr(lk_cattr), .lk_pa(lk_pa)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string phase = "R1";

    // behavioural model of slot contents
    logic [18:0] m_vpn  [N];
    logic [7:0]  m_asid [N];
    logic [11:0] m_pm   [N];
    logic        m_g    [N];
    logic [31:0] m_lo0  [N];
    logic [31:0] m_lo1  [N];

    // expected registered outputs
    logic        e_done, e_flush;
    logic [31:0] e_hi, e_lo0, e_lo1, e_mask, e_idx;
    string       idx_req = "R4";

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s %s: actual %h expected %h", phase, req, what, act, exp);
        end
    endtask

    function automatic int find_slot(input logic [18:0] vpn, input logic [7:0] asid);
        for (int i = 0; i < N; i++) begin
            bit ok;
            ok = m_g[i] || (m_asid[i] == asid);
            for (int j = 0; j < 19; j++) begin
                bit masked;
                masked = (j < 12) && m_pm[i][j];
                if (!masked && (m_vpn[i][j] != vpn[j])) ok = 0;
            end
            if (ok) return i;
        end
        return -1;
    endfunction

    task automatic check_lookup();
        int          s;
        int          p;
        logic [31:0] lo;
        logic [35:0] off, pa;
        s = find_slot(lk_va[31:13], lk_asid);
        if (s < 0) begin
            chk("R12", "lk_hit", 64'(lk_hit), 64'(0));
            chk("R12", "lk_quiet", {lk_valid, lk_dirty, lk_cattr, lk_pa}, 64'(0));
        end else begin
            p = 0;
            while (p < 12 && m_pm[s][p]) p++;
            lo  = lk_va[12 + p] ? m_lo1[s] : m_lo0[s];
            off = (36'd1 << (12 + p)) - 36'd1;
            pa  = ({lo[29:6], 12'h000} & ~off) | ({4'h0, lk_va} & off);
            chk("R9", "lk_hit", 64'(lk_hit), 64'(1));
            chk("R9", "lk_flags", {lk_valid, lk_dirty, lk_cattr}, {lo[1], lo[2], lo[5:3]});
            chk("R9", "lk_pa", 64'(lk_pa), 64'(pa));
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [31:0] hi,
                        input logic [31:0] lo0, input logic [31:0] lo1, input logic [31:0] pm,
                        input logic [31:0] ix, input logic [IW-1:0] rnd,
                        input logic [31:0] va, input logic [7:0] asid);
        int s;
        int w;
        @(negedge clk);
        lk_va   = va;
        lk_asid = asid;
        #1;
        chk("R8", "done", 64'(done), 64'(e_done));
        chk(idx_req, "idx_out", 64'(idx_out), 64'(e_idx));
        chk("R6", "hi_out", 64'(hi_out), 64'(e_hi));
        chk("R6", "lo0_out", 64'(lo0_out), 64'(e_lo0));
        chk("R6", "lo1_out", 64'(lo1_out), 64'(e_lo1));
        chk("R6", "mask_out", 64'(mask_out), 64'(e_mask));
        chk("R7", "asid_flush", 64'(asid_flush), 64'(e_flush));
        check_lookup();
        cmd_valid = v; cmd_op = op; hi_in = hi; lo0_in = lo0; lo1_in = lo1;
        mask_in = pm; idx_in = ix; rand_in = rnd;
        e_done  = v;
        e_flush = 1'b0;
        if (v) begin
            case (op)
                2'd0: begin
                    s = find_slot(hi[31:13], hi[7:0]);
                    if (s >= 0) begin e_idx = 32'(s); idx_req = "R4"; end
                    else begin e_idx = ix | 32'h8000_0000; idx_req = "R5"; end
                end
                2'd1: begin
                    s       = int'(ix % N);
                    e_hi    = {m_vpn[s], 5'b0, m_asid[s]};
                    e_mask  = {7'b0, m_pm[s], 13'b0};
                    e_lo0   = m_lo0[s] | 32'(m_g[s]);
                    e_lo1   = m_lo1[s] | 32'(m_g[s]);
                    e_flush = (m_asid[s] != hi[7:0]);
                end
                default: begin
                    w         = (op == 2'd2) ? int'(ix % N) : int'(rnd);
                    m_vpn[w]  = hi[31:13];
                    m_asid[w] = hi[7:0];
                    m_pm[w]   = pm[24:13];
                    m_g[w]    = lo0[0] & lo1[0];
                    m_lo0[w]  = lo0 & 32'h3FFF_FFFE;
                    m_lo1[w]  = lo1 & 32'h3FFF_FFFE;
                end
            endcase
        end
    endtask

    task automatic wr(input logic [31:0] ix, input logic [31:0] hi, input logic [31:0] lo0,
                      input logic [31:0] lo1, input logic [31:0] pm);
        step(1'b1, 2'd2, hi, lo0, lo1, pm, ix, '0, 32'h0, 8'h0);
    endtask

    task automatic wr_rand(input logic [IW-1:0] r, input logic [31:0] hi, input logic [31:0] lo0,
                           input logic [31:0] lo1, input logic [31:0] pm);
        step(1'b1, 2'd3, hi, lo0, lo1, pm, 32'hFFFF_FFFF, r, 32'h0, 8'h0);
    endtask

    task automatic rd(input logic [31:0] ix, input logic [7:0] cur);
        step(1'b1, 2'd1, {24'h0, cur}, '0, '0, '0, ix, '0, 32'h0, 8'h0);
    endtask

    task automatic probe(input logic [31:0] hi, input logic [31:0] ix);
        step(1'b1, 2'd0, hi, '0, '0, '0, ix, '0, 32'h0, 8'h0);
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid);
        step(1'b0, 2'd0, '0, '0, '0, '0, '0, '0, va, asid);
    endtask

    function automatic logic [31:0] lfsr(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic run_all();
        logic [31:0] r;
        logic [31:0] base [4];
        logic [31:0] pms  [3];
        base[0] = 32'h0040_0000; base[1] = 32'h1000_0000;
        base[2] = 32'h7FFF_0000; base[3] = 32'h0000_0000;
        pms[0]  = 32'h0000_0000; pms[1]  = 32'h0000_6000; pms[2] = 32'h0001_E000;

        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; hi_in = '0; lo0_in = '0; lo1_in = '0;
        mask_in = '0; idx_in = '0; rand_in = '0; lk_va = 32'h0040_0000; lk_asid = 8'h05;
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_pm[i] = '0; m_g[i] = 1'b0; m_lo0[i] = '0; m_lo1[i] = '0;
        end
        e_done = 0; e_flush = 0; e_hi = 0; e_lo0 = 0; e_lo1 = 0; e_mask = 0; e_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        chk("R1", "done", 64'(done), 64'(0));
        chk("R1", "flush", 64'(asid_flush), 64'(0));
        chk("R1", "results", {hi_out, idx_out}, 64'(0));
        chk("R1", "frames", {lo0_out, lo1_out}, 64'(0));
        chk("R1", "mask", 64'(mask_out), 64'(0));
        chk("R1", "lookup_miss", 64'(lk_hit), 64'(0));

        phase = "R2";
        wr(32'h0000_0020, 32'h0040_0005, (32'h123 << 6) | 32'h1E, (32'h124 << 6) | 32'h0A, 32'h0);
        wr(32'h0000_0001, 32'h1000_2007, (32'h555 << 6) | 32'h27, (32'h556 << 6) | 32'h03, 32'hFE00_1FFF);
        wr(32'h0000_0012, 32'h2000_0009, 32'hC000_0000 | (32'hABC0 << 6) | 32'h16,
           (32'hABC4 << 6) | 32'h3E, 32'h0000_6000);
        wr(32'h8000_0005, 32'h3000_0005, (32'h77 << 6) | 32'h03, (32'h78 << 6) | 32'h02, 32'h0);

        phase = "R3";
        wr_rand(4'd9, 32'h4000_0003, (32'h900 << 6) | 32'h02, (32'h901 << 6) | 32'h02, 32'h0);
        wr_rand(4'd7, 32'h4000_0003, (32'h700 << 6) | 32'h06, (32'h701 << 6) | 32'h06, 32'h0);

        phase = "R6";
        rd(32'h0000_0000, 8'h05);
        rd(32'h0000_0011, 8'h07);
        rd(32'h0000_0002, 8'h09);
        rd(32'h0000_0005, 8'h05);
        rd(32'h0000_0009, 8'h03);
        rd(32'h0000_0037, 8'h03);

        phase = "R7";
        rd(32'h0000_0000, 8'h06);
        rd(32'h0000_0001, 8'h07);
        rd(32'h0000_0002, 8'h00);

        phase = "R4";
        probe(32'h0040_0005, 32'h0000_000C);
        probe(32'h4000_0003, 32'h0000_000C);
        phase = "R11";
        probe(32'h1000_2055, 32'h0000_0003);
        phase = "R10";
        probe(32'h2000_6009, 32'h0000_0004);
        phase = "R5";
        probe(32'h3000_0006, 32'h0000_000B);
        probe(32'h0040_0006, 32'h7000_0002);

        phase = "R9";
        look(32'h0040_0123, 8'h05);
        look(32'h0040_1FFF, 8'h05);
        look(32'h2000_2345, 8'h09);
        look(32'h2000_7ABC, 8'h09);
        look(32'h4000_1004, 8'h03);
        phase = "R11";
        look(32'h1000_3456, 8'h99);
        phase = "R10";
        look(32'h2000_4000, 8'h09);
        phase = "R12";
        look(32'h3000_0000, 8'h06);
        look(32'h5555_5000, 8'h01);

        phase = "R8";
        probe(32'h0040_0005, 32'h0);
        rd(32'h0000_0003, 8'h00);
        wr(32'h0000_0003, 32'h0040_0005, (32'h333 << 6) | 32'h02, 32'h0, 32'h0);
        probe(32'h0040_0005, 32'h0);
        look(32'h0040_0000, 8'h05);
        look(32'h0040_0000, 8'h05);

        phase = "RND";
        r = 32'h1ACE_B00C;
        for (int k = 0; k < 600; k++) begin
            logic [31:0] hi;
            logic [31:0] va;
            logic [31:0] a;
            logic [31:0] b;
            r  = lfsr(r); a = r;
            r  = lfsr(r); b = r;
            hi = base[a[1:0]] | (b & 32'h0000_6000) | {31'h0, a[2]};
            va = base[b[3:2]] | (a & 32'h0001_FFFF);
            step(a[5] | a[6], a[8:7], hi, b, {b[15:0], a[31:16]}, pms[a[10:9] % 3],
                 {a[31], 27'h0, b[7:4]}, b[11:8], va, {7'h0, b[12]});
        end

        phase = "END";
        look(32'h0040_0000, 8'h05);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL [%s] watchdog: actual timeout expected completion", phase);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule